// File: doc/BRIEF.md
# Prescaled Gray-Sequence Stepper

This block is a two-bit Moore state machine whose state walks a Gray sequence, so that exactly one bit of the count changes on each step. The state machine runs on the same clock as the rest of the design. It does not advance on every edge. A free-running modulo-N tick generator produces a pulse one clock wide, and the state may move only on an edge where that pulse is high. The step rate is therefore the clock frequency divided by N, and no divided or gated clock is created.

An external run input gates the block. While run is low, both the tick generator and the state machine keep their values. A flag output is high in one of the four states. The tick is also brought out, so that neighbouring logic can share the same rate. The reset is synchronous and active low.

Top module: `gstep_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state returns to 00 and the tick generator returns to 0. After that edge, gray_q is 00, flag is 0, and tick is 0 when DIV_N is 2 or more.
- R2: Each step moves gray_q through the order 00 -> 01 -> 11 -> 10 -> 00. The two-bit value on gray_q is the state encoding itself.
- R3: flag is 1 exactly when gray_q is 10. It depends on the state alone.
- R4: With DIV_N of 2 or more, the tick generator counts 0 up to DIV_N-1 and wraps to 0 on edges where run is high. tick is 1 only while the count equals DIV_N-1, so with run held high it is high for one clock in every DIV_N clocks.
- R5: While run is low, the tick generator count and the state both hold, and tick keeps its level.
- R6: The state advances on a rising edge only when run and tick are both 1. With run held high from reset, the first step happens on edge DIV_N and later steps follow every DIV_N edges.
- R7: A reset in the middle of operation restarts the whole sequence. The next step then comes DIV_N run edges later.
- R8: With DIV_N equal to 1, tick is fixed at 1 and the state advances on every edge where run is high.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Lets the tick generator count and the state advance |
| gray_q | output | 2 | Present state, Gray coded |
| flag | output | 1 | High while the state is 10 |
| tick | output | 1 | High while the tick count equals DIV_N-1 |

## Verification
Assertions check four properties on every cycle. The state holds whenever the advance condition is low. Each step flips exactly one bit, and the state 10 always wraps to 00. The tick count stays frozen while run is low and returns to zero after a counted terminal tick. The flag rises only when the state leaves 11. Some behaviour only the bench scenarios can show. These are the full timing of the sequence, that is, which edge carries each step once run has been paused in the middle of a prescale period. They also include the restart after a mid-run reset and the degenerate divide-by-one variant.

// File: rtl/gstep_pkg.sv
// Package gstep_pkg
// Shared state type and step function for the Gray-sequence stepper.
// Assumes a two-bit state whose encoding is also the visible count.
package gstep_pkg;

    typedef enum logic [1:0] {
        ST_00 = 2'b00,
        ST_01 = 2'b01,
        ST_11 = 2'b11,
        ST_10 = 2'b10
    } gstep_state_e;

    // Successor of a state in the Gray order.
    function automatic gstep_state_e gstep_next(input gstep_state_e cur);
        case (cur)
            ST_00:   return ST_01;
            ST_01:   return ST_11;
            ST_11:   return ST_10;
            default: return ST_00;
        endcase
    endfunction

endpackage

// File: rtl/gstep_tick_gen.sv
// Module gstep_tick_gen
// Modulo-DIV_N counter that raises tick while its count sits at DIV_N-1.
// It counts only while run is high. Assumes DIV_N >= 1; DIV_N == 1 ties tick high.
module gstep_tick_gen #(
    parameter int DIV_N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW   = (DIV_N > 1) ? $clog2(DIV_N) : 1;
    localparam int LAST = DIV_N - 1;

    generate
        if (DIV_N == 1) begin : g_tied
            assign tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            logic          at_last;

            assign at_last = (cnt_q == CW'(LAST));
            assign tick    = at_last;

            // Purpose: advance the modulo count while run is high; sync reset to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (run) begin
                    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
                end
            end

            // R5
            tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> $stable(cnt_q));

            // R4
            tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (run && tick) |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/gstep_fsm.sv
// Module gstep_fsm
// Two-bit Moore machine that takes one Gray step per cycle in which adv is high.
// Assumes adv is a one-cycle qualified pulse produced elsewhere.
module gstep_fsm
    import gstep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    output logic [1:0] state_q,
    output logic       flag
);

    gstep_state_e st_q;

    // Purpose: hold or step the state; sync reset to 00.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_00;
        end else if (adv) begin
            st_q <= gstep_next(st_q);
        end
    end

    assign state_q = st_q;
    assign flag    = (st_q == ST_10);

    // R6
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));

    // R2
    one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ($countones(state_q ^ $past(state_q)) == 1));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state_q == 2'b10) |=> (state_q == 2'b00));

endmodule

// File: rtl/gstep_counter.sv
// Module gstep_counter
// Top level: a Gray-sequence stepper paced by a modulo-DIV_N tick on a single clock.
// Assumes DIV_N >= 1. Reset is synchronous and active low.
module gstep_counter #(
    parameter int DIV_N = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [1:0] gray_q,
    output logic       flag,
    output logic       tick
);

    logic adv;

    gstep_tick_gen #(.DIV_N(DIV_N)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    // Step qualifier: external run combined with the prescale tick.
    assign adv = run & tick;

    gstep_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .state_q (gray_q),
        .flag    (flag)
    );

    // R3
    flag_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(gray_q) == 2'b11));

endmodule

// File: tb/gstep_counter_bench.sv
module gstep_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       run_b = 1'b0;
    logic [1:0] gray_q, gray_b;
    logic       flag, flag_b, tick, tick_b;
    int         checks = 0;
    int         failures = 0;

    always #5 clk = ~clk;

    gstep_counter #(.DIV_N(10)) u_gstep_counter (
        .clk(clk), .rst_n(rst_n), .run(run),
        .gray_q(gray_q), .flag(flag), .tick(tick)
    );

    gstep_counter #(.DIV_N(1)) u_gstep_counter_div1 (
        .clk(clk), .rst_n(rst_n), .run(run_b),
        .gray_q(gray_b), .flag(flag_b), .tick(tick_b)
    );

    // Vector: {run, edges[7:0], pad[2:0], gray[1:0], tick, pad}
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 8'd9,  3'd0, 2'b00, 1'b1, 1'b0},
        {1'b1, 8'd1,  3'd0, 2'b01, 1'b0, 1'b0},
        {1'b0, 8'd25, 3'd0, 2'b01, 1'b0, 1'b0},
        {1'b1, 8'd9,  3'd0, 2'b01, 1'b1, 1'b0},
        {1'b0, 8'd5,  3'd0, 2'b01, 1'b1, 1'b0},
        {1'b1, 8'd1,  3'd0, 2'b11, 1'b0, 1'b0},
        {1'b1, 8'd10, 3'd0, 2'b10, 1'b0, 1'b0},
        {1'b1, 8'd10, 3'd0, 2'b00, 1'b0, 1'b0},
        {1'b1, 8'd4,  3'd0, 2'b00, 1'b0, 1'b0},
        {1'b1, 8'd6,  3'd0, 2'b01, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(2);
        // R1: reset state
        chk("R1 gray", gray_q, 0);
        chk("R1 flag", flag, 0);
        chk("R1 tick", tick, 0);
        rst_n = 1'b1;

        // R2 R4 R5 R6 R3: walk the vector table
        for (int i = 0; i < NV; i++) begin
            run = VEC[i][15];
            step(int'(VEC[i][14:7]));
            chk("R2_R6 gray", gray_q, int'(VEC[i][3:2]));
            chk("R4_R5 tick", tick, int'(VEC[i][1]));
            chk("R3 flag", flag, (VEC[i][3:2] == 2'b10) ? 1 : 0);
        end

        // R7: reset mid-run, then the next step comes DIV_N edges later
        run = 1'b1;
        step(3);
        rst_n = 1'b0;
        step(1);
        chk("R7 gray", gray_q, 0);
        chk("R7 tick", tick, 0);
        rst_n = 1'b1;
        step(9);
        chk("R7 gray before", gray_q, 0);
        step(1);
        chk("R7 gray after", gray_q, 1);
        run = 1'b0;

        // R8: divide-by-one variant steps each run edge
        run_b = 1'b1;
        step(1);
        chk("R8 gray", gray_b, 1);
        chk("R8 tick", tick_b, 1);
        step(1);
        chk("R8 gray", gray_b, 3);
        step(1);
        chk("R8 gray", gray_b, 2);
        chk("R8 flag", flag_b, 1);
        step(1);
        chk("R8 gray", gray_b, 0);
        run_b = 1'b0;
        step(3);
        chk("R8 hold gray", gray_b, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule